// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Read Cache

This block is a direct-mapped read cache that sits between a 32-bit byte-addressed processor and a wider backing memory. Every cache block keeps one address tag, but the block is divided into several sub-blocks, and each sub-block carries a valid flag of its own. A read hits only when the stored tag equals the tag field of the address and the flag of the addressed sub-block is set. On a miss the cache fetches exactly one sub-block from memory, never the whole block.

The processor raises `cpu_req` with an address and keeps both steady until `cpu_hit` comes back. The returned word is picked in two steps: first the sub-block within the indexed block, then the word within that sub-block. The two low address bits (byte within word) play no part in the lookup. On the memory side the cache raises `mem_req` with a sub-block-aligned address and waits for `mem_ready`, which arrives with a whole sub-block on `mem_rdata`. The geometry comes from parameters. The defaults are 16 blocks, each made of four 16-byte sub-blocks, with 32-bit words. That gives, from the top of the address down: a 22-bit tag, a 4-bit index `[9:6]`, a 2-bit sub-block select `[5:4]`, a 2-bit word select `[3:2]` and a 2-bit byte offset `[1:0]`.

The controller has two states. In `ST_LOOKUP` it answers requests. The transition `ST_LOOKUP -> ST_FILL` is taken on a request that misses, and it also captures the address and whether the tag matched. In `ST_FILL` it holds `mem_req`. The transition `ST_FILL -> ST_LOOKUP` is taken in the cycle `mem_ready` is seen, and that same edge writes the sub-block, the tag and the valid flags. A synchronous reset returns the controller to `ST_LOOKUP` from either state.

Top module: `sbc_cache`

## Requirements
- R1: A synchronous active-high `rst` clears every valid flag and puts the controller in `ST_LOOKUP`. After reset, `cpu_hit` and `mem_req` are low, and every first read misses.
- R2: In `ST_LOOKUP`, `cpu_hit` is high in the same cycle as `cpu_req` exactly when the indexed tag equals `cpu_addr` tag bits and the valid flag of sub-block `cpu_addr[5:4]` is set. Other blocks do not affect the result.
- R3: A request that misses in `ST_LOOKUP` raises `mem_req` on the next cycle. `mem_addr` equals `cpu_addr` with bits `[3:0]` cleared, and each miss causes exactly one sub-block fetch.
- R4: A fill completes in a cycle with both `mem_req` and `mem_ready` high. If the same request is still held in the following cycle, it hits.
- R5: `mem_req` stays high with `mem_addr` unchanged until `mem_ready` is seen.
- R6: `cpu_rdata` is the sub-block selected by `cpu_addr[5:4]`, narrowed to bits `[32*w+31 : 32*w]` with `w = cpu_addr[3:2]`, where the sub-block is as returned on `mem_rdata`. Bits `[1:0]` are ignored.
- R7: A miss with a matching tag fetches only the addressed sub-block. Sub-blocks that were already valid in that block keep hitting without any fetch.
- R8: A miss with a different tag writes the new tag and leaves only the fetched sub-block valid. Every other sub-block of that block then misses.
- R9: `cpu_hit` is never high while `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Read request, held until hit |
| cpu_addr | input | 32 | Byte address of the read |
| cpu_hit | output | 1 | Read satisfied this cycle |
| cpu_rdata | output | 32 | Word read, valid with `cpu_hit` |
| mem_req | output | 1 | Sub-block fetch request |
| mem_addr | output | 32 | Sub-block-aligned fetch address |
| mem_ready | input | 1 | Fetch data present on `mem_rdata` |
| mem_rdata | input | 128 | One sub-block, word 0 in the low bits |

## Verification
On a tag mismatch, two actions fall on the same clock edge when the fill completes: the sibling sub-blocks of the block are invalidated, and the fetched sub-block is validated under the new tag. The bench provokes this by first filling several sub-blocks of one block and then reading an alias address that has the same index but a different tag. The result is judged only at the ports. The aliased word must then hit on its own. Both a sibling of the alias and a previously valid sub-block of the old tag must raise a fresh fetch instead of hitting.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } sbc_state_e;
endpackage

// File: rtl/sbc_tag_store.sv
module sbc_tag_store #(
    parameter int BLOCKS = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 22,
    parameter int SUBS   = 4,
    parameter int SSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [SUBS-1:0]   rd_valid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [SSEL_W-1:0] wr_sub,
    input  logic              wr_keep
);
    logic [TAG_W-1:0] tag_q   [BLOCKS];
    logic [SUBS-1:0]  valid_q [BLOCKS];
    logic [SUBS-1:0]  set_mask;

    assign set_mask = SUBS'(1) << wr_sub;
    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BLOCKS; i++) valid_q[i] <= '0;
        end else if (wr_en) begin
            // keep siblings only when the tag was already the same
            valid_q[wr_idx] <= (wr_keep ? valid_q[wr_idx] : '0) | set_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end
endmodule

// File: rtl/sbc_data_store.sv
module sbc_data_store #(
    parameter int BLOCKS = 16,
    parameter int IDX_W  = 4,
    parameter int SUBS   = 4,
    parameter int SSEL_W = 2,
    parameter int SUB_W  = 128,
    parameter int WORD_W = 32,
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SSEL_W-1:0] rd_sub,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic [WORD_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SSEL_W-1:0] wr_sub,
    input  logic [SUB_W-1:0]  wr_data
);
    localparam int ENTRIES = BLOCKS * SUBS;
    localparam int WORDS   = SUB_W / WORD_W;

    logic [SUB_W-1:0]  line_q [ENTRIES];
    logic [SUB_W-1:0]  sub_sel;
    logic [WORD_W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) line_q[{wr_idx, wr_sub}] <= wr_data;
    end

    // first selection: sub-block within the block
    assign sub_sel = line_q[{rd_idx, rd_sub}];

    // second selection: word within the sub-block
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = sub_sel[g*WORD_W +: WORD_W];
    end
    assign rd_word = words[rd_wsel];
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              lookup_hit,
    input  logic              tag_eq,
    input  logic              mem_ready,
    output logic              cpu_hit,
    output logic              fill_busy,
    output logic              fill_done,
    output logic              fill_keep,
    output logic [ADDR_W-1:0] fill_addr
);
    import sbc_pkg::*;

    sbc_state_e  state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              keep_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOOKUP;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cpu_hit   = 1'b0;
        fill_busy = 1'b0;
        fill_done = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    if (lookup_hit) cpu_hit = 1'b1;
                    else            state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                fill_busy = 1'b1;
                if (mem_ready) begin
                    fill_done = 1'b1;
                    state_d   = ST_LOOKUP;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_LOOKUP && cpu_req && !lookup_hit) begin
            addr_q <= cpu_addr;
            keep_q <= tag_eq;
        end
    end

    assign fill_addr = addr_q;
    assign fill_keep = keep_q;
endmodule

// File: rtl/sbc_cache.sv
module sbc_cache #(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int SUB_BYTES = 16,
    parameter int SUBS      = 4,
    parameter int BLOCKS    = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_req,
    input  logic [ADDR_W-1:0]      cpu_addr,
    output logic                   cpu_hit,
    output logic [WORD_W-1:0]      cpu_rdata,
    output logic                   mem_req,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic                   mem_ready,
    input  logic [SUB_BYTES*8-1:0] mem_rdata
);
    localparam int SUB_W  = SUB_BYTES * 8;
    localparam int OFF_W  = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(SUB_BYTES / (WORD_W / 8));
    localparam int SSEL_W = $clog2(SUBS);
    localparam int IDX_W  = $clog2(BLOCKS);
    localparam int LOW_W  = OFF_W + WSEL_W;
    localparam int SUB_LO = LOW_W;
    localparam int IDX_LO = SUB_LO + SSEL_W;
    localparam int TAG_LO = IDX_LO + IDX_W;
    localparam int TAG_W  = ADDR_W - TAG_LO;

    logic [TAG_W-1:0]  lk_tag, st_tag, f_tag;
    logic [IDX_W-1:0]  lk_idx, f_idx;
    logic [SSEL_W-1:0] lk_sub, f_sub;
    logic [WSEL_W-1:0] lk_wsel;
    logic [SUBS-1:0]   st_valid;
    logic              tag_eq, lookup_hit;
    logic              fill_done, fill_keep;
    logic [ADDR_W-1:0] fill_addr;

    assign lk_tag  = cpu_addr[ADDR_W-1:TAG_LO];
    assign lk_idx  = cpu_addr[TAG_LO-1:IDX_LO];
    assign lk_sub  = cpu_addr[IDX_LO-1:SUB_LO];
    assign lk_wsel = cpu_addr[SUB_LO-1:OFF_W];
    assign f_tag   = fill_addr[ADDR_W-1:TAG_LO];
    assign f_idx   = fill_addr[TAG_LO-1:IDX_LO];
    assign f_sub   = fill_addr[IDX_LO-1:SUB_LO];

    assign tag_eq     = (st_tag == lk_tag);
    assign lookup_hit = tag_eq & st_valid[lk_sub];
    assign mem_addr   = {fill_addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};

    sbc_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .lookup_hit(lookup_hit), .tag_eq(tag_eq), .mem_ready(mem_ready),
        .cpu_hit(cpu_hit), .fill_busy(mem_req), .fill_done(fill_done),
        .fill_keep(fill_keep), .fill_addr(fill_addr)
    );

    sbc_tag_store #(
        .BLOCKS(BLOCKS), .IDX_W(IDX_W), .TAG_W(TAG_W), .SUBS(SUBS), .SSEL_W(SSEL_W)
    ) tags_i (
        .clk(clk), .rst(rst), .rd_idx(lk_idx), .rd_tag(st_tag), .rd_valid(st_valid),
        .wr_en(fill_done), .wr_idx(f_idx), .wr_tag(f_tag), .wr_sub(f_sub),
        .wr_keep(fill_keep)
    );

    sbc_data_store #(
        .BLOCKS(BLOCKS), .IDX_W(IDX_W), .SUBS(SUBS), .SSEL_W(SSEL_W),
        .SUB_W(SUB_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
    ) data_i (
        .clk(clk), .rd_idx(lk_idx), .rd_sub(lk_sub), .rd_wsel(lk_wsel),
        .rd_word(cpu_rdata), .wr_en(fill_done), .wr_idx(f_idx), .wr_sub(f_sub),
        .wr_data(mem_rdata)
    );
endmodule

// File: rtl/sbc_cache_chk.sv
module sbc_cache_chk #(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int SUB_BYTES = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cpu_req,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic                   cpu_hit,
    input logic [WORD_W-1:0]      cpu_rdata,
    input logic                   mem_req,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic                   mem_ready,
    input logic [SUB_BYTES*8-1:0] mem_rdata
);
    localparam int LOW_W = $clog2(SUB_BYTES);

    AST_MISS_STARTS_FILL: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_hit && !mem_req) |=> mem_req); // R3

    AST_FILL_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[LOW_W-1:0] == '0)); // R3

    AST_FILL_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R5

    AST_HIT_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && cpu_req) |=>
            (!cpu_req || !$stable(cpu_addr) || cpu_hit)); // R4

    AST_NO_HIT_IN_FILL: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_hit); // R9

    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> cpu_req); // R2
endmodule

bind sbc_cache sbc_cache_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SUB_BYTES(SUB_BYTES)
) chk_i (.*);

// File: tb/sbc_cache_tb_top.sv
module sbc_cache_tb_top;
    typedef struct {
        logic [31:0] d;
        string       r;
    } sb_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic         cpu_hit;
    logic [31:0]  cpu_rdata;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_ready = 1'b0;
    logic [127:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int fill_cnt = 0;
    bit done = 1'b0;
    logic [31:0] exp_fill_addr = '0;
    sb_t sbq[$];

    always #2 clk = ~clk;

    sbc_cache dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] model(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h9E3779B1) ^ 32'hC3D2E1F0;
    endfunction

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // memory model: answers each fetch after three cycles
    initial begin
        int wait_c;
        logic [31:0] cap;
        wait_c = 0;
        cap = '0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                wait_c = 0;
            end else if (mem_req && !rst) begin
                if (wait_c == 0) cap = mem_addr;
                wait_c++;
                if (wait_c == 3) begin
                    check(mem_addr == cap, "R5 fetch address held", mem_addr, cap);
                    check(mem_addr == exp_fill_addr, "R3 fetch address aligned",
                          mem_addr, exp_fill_addr);
                    check(!cpu_hit, "R9 no hit during fill", 32'(cpu_hit), 0);
                    for (int k = 0; k < 4; k++) mem_rdata[32*k +: 32] = model(cap + 32'(4*k));
                    mem_ready = 1'b1;
                    fill_cnt++;
                end
            end else begin
                wait_c = 0;
            end
        end
    end

    // monitor: compares every returned word against the scoreboard
    initial begin
        sb_t it;
        forever begin
            @(negedge clk);
            if (cpu_req && cpu_hit) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R2 unexpected hit", cpu_rdata, 0);
                end else begin
                    it = sbq.pop_front();
                    check(cpu_rdata == it.d, it.r, cpu_rdata, it.d);
                end
            end
        end
    end

    task automatic do_read(input logic [31:0] a, input bit exp_fill, input string rq);
        int f0;
        bit seen;
        sb_t it;
        f0 = fill_cnt;
        it.d = model(a);
        it.r = {rq, " data"};
        sbq.push_back(it);
        exp_fill_addr = {a[31:4], 4'h0};
        cpu_addr = a;
        cpu_req = 1'b1;
        @(negedge clk);
        check(cpu_hit == !exp_fill, {rq, " first-cycle hit"}, 32'(cpu_hit), 32'(!exp_fill));
        seen = cpu_hit;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            seen = cpu_hit;
        end
        check(seen, {rq, " hit after fill"}, 32'(seen), 1);
        check(fill_cnt - f0 == int'(exp_fill), {rq, " fetch count"},
              32'(fill_cnt - f0), 32'(exp_fill));
        @(posedge clk);
        #1 cpu_req = 1'b0;
    endtask

    localparam logic [31:0] A_BASE = 32'h0000_1040; // index 1, tag X
    localparam logic [31:0] B_BASE = 32'h0000_2040; // index 1, tag Y
    localparam logic [31:0] C_BASE = 32'h0000_1080; // index 2

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!cpu_hit, "R1 reset hit low", 32'(cpu_hit), 0);
        check(!mem_req, "R1 reset fetch low", 32'(mem_req), 0);

        do_read(A_BASE + 32'h04, 1'b1, "R1 R3 first read misses");
        do_read(A_BASE + 32'h0E, 1'b0, "R2 R6 same sub-block hit, byte bits ignored");
        do_read(A_BASE + 32'h10, 1'b1, "R7 tag match, sub-block 1 fetched");
        do_read(A_BASE + 32'h00, 1'b0, "R7 sub-block 0 still valid");
        do_read(A_BASE + 32'h38, 1'b1, "R6 sub-block 3 word 2");
        do_read(A_BASE + 32'h14, 1'b0, "R4 R7 sub-block 1 word 1");
        do_read(B_BASE + 32'h24, 1'b1, "R8 alias tag fetched");
        do_read(B_BASE + 32'h28, 1'b0, "R8 alias sub-block valid");
        do_read(B_BASE + 32'h04, 1'b1, "R8 alias sibling invalid");
        do_read(A_BASE + 32'h00, 1'b1, "R8 old tag evicted");
        do_read(A_BASE + 32'h10, 1'b1, "R8 old siblings cleared");
        do_read(C_BASE + 32'h3C, 1'b1, "R2 other index miss");
        do_read(A_BASE + 32'h0C, 1'b0, "R2 index 1 unaffected by index 2");

        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        do_read(C_BASE + 32'h3C, 1'b1, "R1 reset clears valid flags");

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R2 scoreboard drained", 32'(sbq.size()), 0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule